// File: doc/BRIEF.md
# Segment Address Translator with Descriptor Cache

This block generates addresses for a single segment register. In real mode, the segment value marks the base of a 64K-byte window. The unit adds a 16-bit offset to that base and returns a 20-bit physical address. No fetch is involved in this mode, and no access faults.

In protected mode, writing a selector starts a descriptor load from either the global or the local table. The descriptor is 8 bytes and is read as two 32-bit words through a simple read port. The unit keeps the base, the effective limit and the write permission in a hidden cache. Every later access is translated as base plus offset from that cache, without going back to the table. The same access is also checked against the limit and the write permission.

A selector can fail in two ways. If it points past the table limit, the unit flags a fault and keeps the previous cache. If it is the null entry of the global table, it loads without error, but every access through it then faults. The requested privilege level is only reported, never compared.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `prot_mode` low, a selector write loads the 16-bit segment on the next edge and never raises `busy`. An access returns `(segment*16 + acc_off[15:0]) mod 2^20` with bits 31:20 zero and `xl_fault` low; `acc_off[31:16]` and `acc_wr` are ignored.
- R2: A protected selector splits into three fields: bits 15:3 are the index, bit 2 picks the table (0 global, 1 local) and bits 1:0 are the requested privilege level. `rpl` shows bits 1:0 of the last selector that loaded.
- R3: A protected selector load makes exactly two reads, first at table base + index*8 and then at that address + 4. Each read request lasts one cycle, and `busy` is high from the cycle after the write until the descriptor is in the cache.
- R4: Descriptor layout: the word at +0 is the 32-bit base. In the word at +4, bits 19:0 are the limit, bit 20 is granularity and bit 21 is write-enable.
- R5: If index*8+7 is greater than the chosen table's limit, `sel_fault` pulses for one cycle after the write. No read is made, and the cached descriptor and `rpl` stay as they were.
- R6: A global selector with index 0 makes no read and raises no `sel_fault`. Every later protected access through it faults. Index 0 of the local table is fetched like any other entry.
- R7: A protected access returns `xl_vld` one cycle later, with `xl_addr` equal to base + offset (mod 2^32).
- R8: A protected access faults when the offset exceeds the limit. With granularity set, the limit is counted as limit*4096 + 4095.
- R9: A protected write to a descriptor with write-enable clear faults; a read through the same descriptor does not.
- R10: Accesses make no memory reads. A change to the table in memory after a load has no effect on translation until the next selector load.
- R11: While `busy` is high, selector writes are ignored and protected accesses fault.
- R12: After reset, `busy`, `mem_rd_req`, `xl_vld` and `sel_fault` are low, the real segment is 0, and a protected access before any load faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_mode | input | 1 | 1 selects protected translation, 0 real mode |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table last valid byte offset |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table last valid byte offset |
| sel_wr | input | 1 | Write strobe for the segment register |
| sel_val | input | 16 | Segment value or selector to write |
| busy | output | 1 | Descriptor load in progress |
| sel_fault | output | 1 | One-cycle pulse: selector beyond table limit |
| rpl | output | 2 | Requested privilege level of the loaded selector |
| mem_rd_req | output | 1 | Table read request, one cycle per word |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data word |
| acc_vld | input | 1 | Access request |
| acc_wr | input | 1 | Access is a write |
| acc_off | input | 32 | Access offset |
| xl_vld | output | 1 | Translation result valid |
| xl_addr | output | 32 | Translated address |
| xl_fault | output | 1 | Access violates the limit, permission, null or busy rule |

## Verification
Some rules can be checked on every cycle and need no knowledge of the cached descriptor. Read requests appear only while busy and last one cycle, and a failed selector never starts a fetch. The result strobe follows the access strobe by one cycle. Real-mode results stay fault-free and inside 20 bits, and a protected access made while busy always faults.

Other behaviour only the bench scenarios can show. The exact translated address and the limit with and without granularity are among them. Stale cache contents after the table is rewritten, the survival of the old descriptor after a rejected selector, and null-selector handling also need scenarios, because each depends on what memory held when the selector was loaded.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int SEG_ADDR_W     = 32;
   localparam int SEG_LIM_W      = 20;
   localparam int SEG_GRAN_SHIFT = 12;
   localparam int DESC_GRAN_BIT  = 20;
   localparam int DESC_WR_BIT    = 21;

   typedef enum logic [2:0] {
      F_IDLE,
      F_REQ_LO,
      F_WAIT_LO,
      F_REQ_HI,
      F_WAIT_HI
   } fetch_st_e;

   // descriptor as decoded from the two table words
   typedef struct packed {
      logic [SEG_ADDR_W-1:0] base;
      logic [SEG_LIM_W-1:0]  limit;
      logic                  gran;
      logic                  wr;
      logic                  is_null;
   } desc_t;

   // hidden part of the segment register
   typedef struct packed {
      logic                  vld;
      logic                  is_null;
      logic                  wr;
      logic [SEG_ADDR_W-1:0] base;
      logic [SEG_ADDR_W-1:0] eff_lim;
   } cache_t;
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_pkg::*;
#(
   parameter int ADDR_W    = SEG_ADDR_W,
   parameter int SEL_W     = 16,
   parameter int TBL_LIM_W = 16,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_mode,
   input  logic [ADDR_W-1:0] gdt_base,
   input  logic [TBL_LIM_W-1:0] gdt_limit,
   input  logic [ADDR_W-1:0] ldt_base,
   input  logic [TBL_LIM_W-1:0] ldt_limit,
   input  logic              sel_wr,
   input  logic [SEL_W-1:0]  sel_val,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              busy,
   output logic              ld_en,
   output desc_t             ld_desc,
   output logic [1:0]        ld_rpl,
   output logic              sel_fault
);
   localparam int ENTRY_SH = 3;
   localparam int IDX_W    = SEL_W - ENTRY_SH;
   localparam int HI_OFS   = DATA_W / 8;
   localparam int PAD_W    = ADDR_W - SEL_W;

   if (DATA_W * 2 != 64) begin : g_bad_data
      $error("descriptor must be two data words of 64 bits total");
   end
   if (TBL_LIM_W != SEL_W) begin : g_bad_lim
      $error("table limit width must equal selector width");
   end
   if (ADDR_W != SEG_ADDR_W || PAD_W < 0) begin : g_bad_addr
      $error("address width mismatch");
   end

   fetch_st_e            state_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [1:0]           rpl_q;
   logic [DATA_W-1:0]    lo_q;
   logic                 fault_q;

   logic [IDX_W-1:0]     idx;
   logic                 ti;
   logic                 null_sel;
   logic                 over_lim;
   logic                 accept;
   logic [ADDR_W-1:0]    tbl_base;
   logic [TBL_LIM_W-1:0] tbl_lim;
   logic [SEL_W-1:0]     last_byte;
   logic [ADDR_W-1:0]    entry_addr;
   logic                 unused_hi;

   assign idx        = sel_val[SEL_W-1:ENTRY_SH];
   assign ti         = sel_val[2];
   assign null_sel   = !ti && (idx == '0);
   assign tbl_base   = ti ? ldt_base : gdt_base;
   assign tbl_lim    = ti ? ldt_limit : gdt_limit;
   assign last_byte  = {idx, {ENTRY_SH{1'b1}}};
   assign over_lim   = last_byte > tbl_lim;
   assign entry_addr = tbl_base + {{PAD_W{1'b0}}, idx, {ENTRY_SH{1'b0}}};
   assign accept     = sel_wr && prot_mode && (state_q == F_IDLE);
   assign unused_hi  = ^mem_rd_data[DATA_W-1:DESC_WR_BIT+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= F_IDLE;
         addr_q  <= '0;
         rpl_q   <= '0;
         lo_q    <= '0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= 1'b0;
         unique case (state_q)
            F_IDLE: begin
               if (accept && !null_sel) begin
                  if (over_lim) begin
                     fault_q <= 1'b1;
                  end else begin
                     addr_q  <= entry_addr;
                     rpl_q   <= sel_val[1:0];
                     state_q <= F_REQ_LO;
                  end
               end
            end
            F_REQ_LO: state_q <= F_WAIT_LO;
            F_WAIT_LO: begin
               if (mem_rd_valid) begin
                  lo_q    <= mem_rd_data;
                  state_q <= F_REQ_HI;
               end
            end
            F_REQ_HI: state_q <= F_WAIT_HI;
            F_WAIT_HI: begin
               if (mem_rd_valid) state_q <= F_IDLE;
            end
            default: state_q <= F_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != F_IDLE);
   assign mem_rd_req  = (state_q == F_REQ_LO) || (state_q == F_REQ_HI);
   assign mem_rd_addr = (state_q == F_REQ_HI) ? addr_q + ADDR_W'(HI_OFS) : addr_q;
   assign sel_fault   = fault_q;

   always_comb begin
      ld_en   = 1'b0;
      ld_desc = '0;
      ld_rpl  = rpl_q;
      if (accept && null_sel) begin
         ld_en           = 1'b1;
         ld_desc.is_null = 1'b1;
         ld_rpl          = sel_val[1:0];
      end else if (state_q == F_WAIT_HI && mem_rd_valid) begin
         ld_en         = 1'b1;
         ld_desc.base  = lo_q;
         ld_desc.limit = mem_rd_data[SEG_LIM_W-1:0];
         ld_desc.gran  = mem_rd_data[DESC_GRAN_BIT];
         ld_desc.wr    = mem_rd_data[DESC_WR_BIT];
      end
   end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
   import seg_pkg::*;
#(
   parameter int ADDR_W     = SEG_ADDR_W,
   parameter int LIM_W      = SEG_LIM_W,
   parameter int GRAN_SHIFT = SEG_GRAN_SHIFT,
   parameter int SEL_W      = 16,
   parameter bit GRAN_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             real_wr,
   input  logic [SEL_W-1:0] sel_val,
   input  logic             ld_en,
   input  desc_t            ld_desc,
   input  logic [1:0]       ld_rpl,
   output logic [SEL_W-1:0] real_seg,
   output cache_t           cache,
   output logic [1:0]       rpl
);
   localparam int ZPAD_W = ADDR_W - LIM_W;

   if (LIM_W + GRAN_SHIFT != ADDR_W) begin : g_bad_gran
      $error("scaled limit must fill the address width");
   end
   if (LIM_W != SEG_LIM_W || ADDR_W != SEG_ADDR_W) begin : g_bad_pkg
      $error("cache widths must match the package types");
   end

   logic [ADDR_W-1:0] eff_lim_new;

   if (GRAN_EN) begin : g_gran
      assign eff_lim_new = ld_desc.gran ? {ld_desc.limit, {GRAN_SHIFT{1'b1}}}
                                        : {{ZPAD_W{1'b0}}, ld_desc.limit};
   end else begin : g_byte
      logic unused_gran;
      assign unused_gran = ld_desc.gran;
      assign eff_lim_new = {{ZPAD_W{1'b0}}, ld_desc.limit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         real_seg <= '0;
         cache    <= '0;
         rpl      <= '0;
      end else begin
         if (real_wr) real_seg <= sel_val;
         if (ld_en) begin
            cache.vld     <= 1'b1;
            cache.is_null <= ld_desc.is_null;
            cache.wr      <= ld_desc.wr;
            cache.base    <= ld_desc.base;
            cache.eff_lim <= eff_lim_new;
            rpl           <= ld_rpl;
         end
      end
   end
endmodule

// File: rtl/seg_addr_check.sv
module seg_addr_check
   import seg_pkg::*;
#(
   parameter int ADDR_W      = SEG_ADDR_W,
   parameter int OFF_W       = 32,
   parameter int SEG_W       = 16,
   parameter int REAL_ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_mode,
   input  logic              busy,
   input  logic              acc_vld,
   input  logic              acc_wr,
   input  logic [OFF_W-1:0]  acc_off,
   input  logic [SEG_W-1:0]  real_seg,
   input  cache_t            cache,
   output logic              xl_vld,
   output logic [ADDR_W-1:0] xl_addr,
   output logic              xl_fault
);
   localparam int REAL_SH = REAL_ADDR_W - SEG_W;
   localparam int HI_PAD  = ADDR_W - REAL_ADDR_W;

   if (OFF_W != ADDR_W) begin : g_bad_off
      $error("offset width must equal address width");
   end
   if (REAL_SH <= 0 || HI_PAD < 0) begin : g_bad_real
      $error("real-mode address must be wider than the segment");
   end

   logic [REAL_ADDR_W-1:0] real_sum;
   logic [ADDR_W-1:0]      prot_sum;
   logic                   prot_bad;
   logic [ADDR_W-1:0]      addr_d;
   logic                   fault_d;

   assign real_sum = {real_seg, {REAL_SH{1'b0}}}
                   + {{REAL_SH{1'b0}}, acc_off[SEG_W-1:0]};
   assign prot_sum = cache.base + acc_off;
   assign prot_bad = busy || !cache.vld || cache.is_null
                   || (acc_off > cache.eff_lim)
                   || (acc_wr && !cache.wr);

   always_comb begin
      if (prot_mode) begin
         addr_d  = prot_sum;
         fault_d = prot_bad;
      end else begin
         addr_d  = {{HI_PAD{1'b0}}, real_sum};
         fault_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_vld   <= 1'b0;
         xl_addr  <= '0;
         xl_fault <= 1'b0;
      end else begin
         xl_vld <= acc_vld;
         if (acc_vld) begin
            xl_addr  <= addr_d;
            xl_fault <= fault_d;
         end else begin
            xl_fault <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_pkg::*;
#(
   parameter int ADDR_W      = SEG_ADDR_W,
   parameter int SEL_W       = 16,
   parameter int TBL_LIM_W   = 16,
   parameter int DATA_W      = 32,
   parameter int REAL_ADDR_W = 20,
   parameter bit GRAN_EN     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prot_mode,
   input  logic [ADDR_W-1:0]    gdt_base,
   input  logic [TBL_LIM_W-1:0] gdt_limit,
   input  logic [ADDR_W-1:0]    ldt_base,
   input  logic [TBL_LIM_W-1:0] ldt_limit,
   input  logic                 sel_wr,
   input  logic [SEL_W-1:0]     sel_val,
   output logic                 busy,
   output logic                 sel_fault,
   output logic [1:0]           rpl,
   output logic                 mem_rd_req,
   output logic [ADDR_W-1:0]    mem_rd_addr,
   input  logic                 mem_rd_valid,
   input  logic [DATA_W-1:0]    mem_rd_data,
   input  logic                 acc_vld,
   input  logic                 acc_wr,
   input  logic [ADDR_W-1:0]    acc_off,
   output logic                 xl_vld,
   output logic [ADDR_W-1:0]    xl_addr,
   output logic                 xl_fault
);
   logic             ld_en;
   desc_t            ld_desc;
   logic [1:0]       ld_rpl;
   logic [SEL_W-1:0] real_seg;
   cache_t           cache;
   logic             real_wr;

   assign real_wr = sel_wr && !prot_mode;

   seg_desc_fetch #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .TBL_LIM_W(TBL_LIM_W), .DATA_W(DATA_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
      .gdt_base(gdt_base), .gdt_limit(gdt_limit),
      .ldt_base(ldt_base), .ldt_limit(ldt_limit),
      .sel_wr(sel_wr), .sel_val(sel_val),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .busy(busy), .ld_en(ld_en), .ld_desc(ld_desc), .ld_rpl(ld_rpl),
      .sel_fault(sel_fault)
   );

   seg_desc_cache #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .GRAN_EN(GRAN_EN)
   ) u_cache (
      .clk(clk), .rst_n(rst_n), .real_wr(real_wr), .sel_val(sel_val),
      .ld_en(ld_en), .ld_desc(ld_desc), .ld_rpl(ld_rpl),
      .real_seg(real_seg), .cache(cache), .rpl(rpl)
   );

   seg_addr_check #(
      .ADDR_W(ADDR_W), .OFF_W(ADDR_W), .SEG_W(SEL_W), .REAL_ADDR_W(REAL_ADDR_W)
   ) u_check (
      .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .busy(busy),
      .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_off(acc_off),
      .real_seg(real_seg), .cache(cache),
      .xl_vld(xl_vld), .xl_addr(xl_addr), .xl_fault(xl_fault)
   );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int ADDR_W      = 32,
   parameter int REAL_ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prot_mode,
   input logic              sel_wr,
   input logic              busy,
   input logic              sel_fault,
   input logic              mem_rd_req,
   input logic              acc_vld,
   input logic              xl_vld,
   input logic              xl_fault,
   input logic [ADDR_W-1:0] xl_addr
);
   // R3: reads only during a load, each request a single cycle
   a_r3_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> busy);
   a_r3_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   // R5: a rejected selector starts no fetch
   a_r5_fault_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fault |-> (!busy && !mem_rd_req));

   // R7: result strobe follows access strobe by one cycle
   a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld |=> xl_vld);
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld |=> (!xl_vld && !xl_fault));

   // R1: real mode never faults, stays within 20 bits, never busies
   a_r1_real_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !prot_mode) |=>
         (!xl_fault && xl_addr[ADDR_W-1:REAL_ADDR_W] == '0));
   a_r1_real_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && !prot_mode && !busy) |=> !busy);

   // R11: protected access during a load faults
   a_r11_busy_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && prot_mode && busy) |=> xl_fault);
endmodule

bind seg_xlate_unit seg_xlate_chk #(
   .ADDR_W(ADDR_W), .REAL_ADDR_W(REAL_ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .sel_wr(sel_wr),
   .busy(busy), .sel_fault(sel_fault), .mem_rd_req(mem_rd_req),
   .acc_vld(acc_vld), .xl_vld(xl_vld), .xl_fault(xl_fault), .xl_addr(xl_addr)
);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_mode = 1'b0;
   logic [31:0] gdt_base = 32'h0000_0000;
   logic [15:0] gdt_limit = 16'h0027;
   logic [31:0] ldt_base = 32'h0000_0080;
   logic [15:0] ldt_limit = 16'h000F;
   logic        sel_wr = 1'b0;
   logic [15:0] sel_val = '0;
   logic        busy, sel_fault;
   logic [1:0]  rpl;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        acc_vld = 1'b0, acc_wr = 1'b0;
   logic [31:0] acc_off = '0;
   logic        xl_vld, xl_fault;
   logic [31:0] xl_addr;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   seg_xlate_unit u0 (
      .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
      .gdt_base(gdt_base), .gdt_limit(gdt_limit),
      .ldt_base(ldt_base), .ldt_limit(ldt_limit),
      .sel_wr(sel_wr), .sel_val(sel_val), .busy(busy), .sel_fault(sel_fault),
      .rpl(rpl), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_off(acc_off),
      .xl_vld(xl_vld), .xl_addr(xl_addr), .xl_fault(xl_fault)
   );

   // table memory: 64 words, one-cycle read latency
   logic [31:0] mem [0:63];
   int          rd_cnt = 0;
   logic [31:0] last_addr = '0, prev_addr = '0;
   always @(posedge clk) begin
      mem_rd_valid <= mem_rd_req;
      if (mem_rd_req) begin
         mem_rd_data <= mem[mem_rd_addr[7:2]];
         rd_cnt      <= rd_cnt + 1;
         prev_addr   <= last_addr;
         last_addr   <= mem_rd_addr;
      end
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [31:0] off,
                         output logic flt, output logic [31:0] addr);
      @(negedge clk);
      acc_vld = 1'b1; acc_wr = wr; acc_off = off;
      @(negedge clk);
      acc_vld = 1'b0; acc_wr = 1'b0;
      flt = xl_fault; addr = xl_addr;
      chk(xl_vld, "R7", "xl_vld after access", 32'(xl_vld), 1);
   endtask

   task automatic load_sel(input logic [15:0] v, output logic sf, output logic bz);
      @(negedge clk);
      sel_wr = 1'b1; sel_val = v;
      @(negedge clk);
      sel_wr = 1'b0;
      sf = sel_fault; bz = busy;
      while (busy) @(negedge clk);
   endtask

   // vectors: sel, wr, off, fault, addr
   localparam int NV = 13;
   localparam logic [81:0] VEC [0:NV-1] = '{
      {16'h0008, 1'b0, 32'h0000_0000, 1'b0, 32'h0010_0000},
      {16'h0008, 1'b1, 32'h0000_00FF, 1'b0, 32'h0010_00FF},
      {16'h0008, 1'b0, 32'h0000_0100, 1'b1, 32'h0},
      {16'h0012, 1'b0, 32'h0000_1FFF, 1'b0, 32'h0020_1FFF},
      {16'h0012, 1'b0, 32'h0000_2000, 1'b1, 32'h0},
      {16'h0012, 1'b1, 32'h0000_0010, 1'b1, 32'h0},
      {16'h0018, 1'b0, 32'h0000_1000, 1'b0, 32'h0000_0000},
      {16'h0018, 1'b1, 32'h0001_0000, 1'b1, 32'h0},
      {16'h0004, 1'b1, 32'h0000_0010, 1'b0, 32'h0003_0010},
      {16'h0004, 1'b0, 32'h0000_0011, 1'b1, 32'h0},
      {16'h000F, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'h003F_FFFF},
      {16'h000F, 1'b1, 32'h8000_0000, 1'b0, 32'h8040_0000},
      {16'h000F, 1'b0, 32'h0000_0000, 1'b0, 32'h0040_0000}
   };

   initial begin
      #(8 * 50000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic        flt, sf, bz;
      logic [31:0] a;
      logic [15:0] cur;
      int          r0;

      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      mem[2]  = 32'h0010_0000; mem[3]  = 32'h0020_00FF; // byte gran, writable
      mem[4]  = 32'h0020_0000; mem[5]  = 32'h0010_0001; // 4K gran, read-only
      mem[6]  = 32'hFFFF_F000; mem[7]  = 32'h0020_FFFF;
      mem[32] = 32'h0003_0000; mem[33] = 32'h0020_0010; // local idx 0
      mem[34] = 32'h0040_0000; mem[35] = 32'h003F_FFFF; // local idx 1, 4G

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(!busy, "R12", "busy after reset", 32'(busy), 0);
      chk(!mem_rd_req, "R12", "mem_rd_req after reset", 32'(mem_rd_req), 0);
      chk(!xl_vld, "R12", "xl_vld after reset", 32'(xl_vld), 0);
      chk(!sel_fault, "R12", "sel_fault after reset", 32'(sel_fault), 0);
      access(1'b0, 32'h0000_0040, flt, a);
      chk(a == 32'h40, "R12", "real segment zero at reset", a, 32'h40);
      prot_mode = 1'b1;
      access(1'b0, 32'h0, flt, a);
      chk(flt, "R12", "protected access before load faults", 32'(flt), 1);

      // R1 real mode
      prot_mode = 1'b0;
      load_sel(16'h1000, sf, bz);
      chk(!bz, "R1", "no busy on real write", 32'(bz), 0);
      access(1'b0, 32'h0000_F000, flt, a);
      chk(a == 32'h0001_F000 && !flt, "R1", "1000:F000", a, 32'h0001_F000);
      load_sel(16'hFFFF, sf, bz);
      access(1'b1, 32'h0000_0010, flt, a);
      chk(a == 32'h0 && !flt, "R1", "FFFF:0010 wraps", a, 32'h0);
      load_sel(16'h1234, sf, bz);
      access(1'b0, 32'hABCD_0005, flt, a);
      chk(a == 32'h0001_2345 && !flt, "R1", "upper offset ignored", a, 32'h0001_2345);

      // R2 R3 R4 R7 R8 R9 vector walk in protected mode
      prot_mode = 1'b1;
      cur = 16'hFFFF;
      for (int i = 0; i < NV; i++) begin
         logic [15:0] vs; logic vw, vf; logic [31:0] vo, va, tb;
         {vs, vw, vo, vf, va} = VEC[i];
         if (vs != cur) begin
            r0 = rd_cnt;
            load_sel(vs, sf, bz);
            tb = vs[2] ? 32'h80 : 32'h0;
            chk(bz && !sf, "R3", "busy after selector write", 32'(bz), 1);
            chk(rd_cnt - r0 == 2, "R3", "two reads per load", 32'(rd_cnt - r0), 2);
            chk(prev_addr == tb + {16'h0, vs[15:3], 3'b000}, "R3", "first read address",
                prev_addr, tb + {16'h0, vs[15:3], 3'b000});
            chk(last_addr == prev_addr + 4, "R3", "second read address", last_addr, prev_addr + 4);
            chk(rpl == vs[1:0], "R2", "rpl reported", 32'(rpl), 32'(vs[1:0]));
            cur = vs;
         end
         r0 = rd_cnt;
         access(vw, vo, flt, a);
         chk(flt == vf, "R8", $sformatf("fault vec %0d (R9 write rule)", i), 32'(flt), 32'(vf));
         if (!vf) chk(a == va, "R7", $sformatf("addr vec %0d (R4 layout)", i), a, va);
         chk(rd_cnt == r0, "R10", "access makes no read", 32'(rd_cnt - r0), 0);
      end

      // R5 table limit rejects, cache kept
      r0 = rd_cnt;
      load_sel(16'h0028, sf, bz);
      chk(sf && !bz, "R5", "global over limit faults", 32'(sf), 1);
      load_sel(16'h0014, sf, bz);
      chk(sf && !bz, "R5", "local over limit faults", 32'(sf), 1);
      repeat (2) @(negedge clk);
      chk(rd_cnt == r0, "R5", "no reads on rejected selector", 32'(rd_cnt - r0), 0);
      chk(rpl == 2'd3, "R5", "rpl unchanged", 32'(rpl), 3);
      access(1'b0, 32'h0, flt, a);
      chk(!flt && a == 32'h0040_0000, "R5", "old descriptor kept", a, 32'h0040_0000);

      // R10 table change after load is not seen
      load_sel(16'h0008, sf, bz);
      mem[2] = 32'h0050_0000;
      access(1'b0, 32'h4, flt, a);
      chk(!flt && a == 32'h0010_0004, "R10", "cached base reused", a, 32'h0010_0004);
      mem[2] = 32'h0010_0000;

      // R11 writes ignored and accesses fault while busy
      @(negedge clk);
      sel_wr = 1'b1; sel_val = 16'h0012;
      @(negedge clk);
      sel_val = 16'h0018; acc_vld = 1'b1; acc_wr = 1'b0; acc_off = 32'h0;
      chk(busy, "R11", "busy during load", 32'(busy), 1);
      @(negedge clk);
      sel_wr = 1'b0; acc_vld = 1'b0;
      chk(xl_fault, "R11", "access during busy faults", 32'(xl_fault), 1);
      while (busy) @(negedge clk);
      chk(rpl == 2'd2, "R11", "second write ignored (rpl)", 32'(rpl), 2);
      access(1'b0, 32'h0, flt, a);
      chk(!flt && a == 32'h0020_0000, "R11", "first selector loaded", a, 32'h0020_0000);

      // R6 null selector
      r0 = rd_cnt;
      load_sel(16'h0003, sf, bz);
      chk(!sf && !bz, "R6", "null loads without fault", 32'(sf), 0);
      chk(rd_cnt == r0, "R6", "null makes no read", 32'(rd_cnt - r0), 0);
      chk(rpl == 2'd3, "R6", "null rpl reported", 32'(rpl), 3);
      access(1'b0, 32'h0, flt, a);
      chk(flt, "R6", "read through null faults", 32'(flt), 1);
      access(1'b1, 32'h10, flt, a);
      chk(flt, "R6", "write through null faults", 32'(flt), 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule